// File: doc/BRIEF.md
# Codec Serial Command Frame Controller

This block sits on the digital side of a converter interface. It frames 16-bit words that arrive on a serial data input, most significant bit first, one bit per shift strobe. Each word's fourteen upper bits become the next DAC sample. Its two low bits are an in-band command. That command can leave the conversion timing alone, stretch or shrink only the next conversion period by a signed offset, or ask for a second, configuration-carrying word to be framed after the current one. No DAC update is ever skipped.

Two conversion-period dividers run on the master clock, one for the transmit side and one for the receive side. Each reloads from a programmable base count, and for a single period it uses the base plus or minus a signed adjustment. Every transmit period tick starts a primary frame. A primary word coded for a secondary transfer is followed by four idle shift strobes and then a secondary frame with the same timing. The secondary word is held in its own register. The receive frame strobe marks only primary frames. In dual-word mode a separate data-frame strobe marks only secondary frames, and the secondary receive data is passed to the serial output.

Top module: `codec_cmd_framer`

## Requirements
- R1: Each primary frame samples 16 bits on `sdi`, one per `shift_en` cycle, the first being bit 15; bits 15..2 appear on `dac_word` with a one-cycle `dac_valid` pulse for every command code, and `dac_word` is not changed by anything else.
- R2: Command code 00 (bits 1:0) keeps the periods at their base values: `tx_tick` repeats every `base_tx` master clocks and `rx_tick` every `base_rx` clocks.
- R3: Command code 01 makes the next transmit period `base_tx + adj_tx` clocks and the next receive period `base_rx + adj_rx` clocks, with the adjustments taken as two's-complement signed values.
- R4: Command code 10 makes the next transmit period `base_tx - adj_tx` and the next receive period `base_rx - adj_rx`.
- R5: An adjustment applies to exactly one period; the period after it returns to the base count unless another adjusting word has arrived.
- R6: After a primary word with code 11, `tx_fs_n` stays high for exactly four `shift_en` cycles and then goes low for a 16-bit secondary frame; that word appears on `sec_word` with a one-cycle `sec_valid` pulse and never reaches `dac_word`.
- R7: `rx_fs_n` is low only during primary frames, for 16 shift periods each, and never during secondary frames.
- R8: With `dual_mode` high, `fsd_n` is low exactly during secondary frames and `sdo` follows `rx_sdi` there; otherwise `fsd_n` is high and `sdo` is 0.
- R9: A transmit tick that lands in the post-primary gap or in a secondary frame raises `err_overlap` for one cycle; the secondary frame completes, and that tick's primary frame is dropped.
- R10: Under reset all frame strobes are high (inactive), valid and error outputs are low, and the first `tx_tick` comes two master clocks after reset is released; a frame starts on the first `shift_en` cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | One-cycle strobe per shift-clock period |
| sdi | input | 1 | Serial word input, MSB first |
| dual_mode | input | 1 | Enables data-frame strobe and secondary routing |
| rx_sdi | input | 1 | Secondary receive data for routing to `sdo` |
| base_tx | input | CNT_W | Transmit period base count |
| adj_tx | input | CNT_W | Transmit signed adjustment |
| base_rx | input | CNT_W | Receive period base count |
| adj_rx | input | CNT_W | Receive signed adjustment |
| tx_fs_n | output | 1 | Transmit frame sync, low during any frame |
| rx_fs_n | output | 1 | Receive frame sync, low during primary frames |
| fsd_n | output | 1 | Data-frame strobe, low during secondary frames in dual mode |
| sdo | output | 1 | Routed secondary receive data |
| tx_tick | output | 1 | Transmit conversion-period tick |
| rx_tick | output | 1 | Receive conversion-period tick |
| dac_word | output | WORD_W-2 | Captured DAC sample |
| dac_valid | output | 1 | New DAC sample pulse |
| sec_word | output | WORD_W | Captured secondary word |
| sec_valid | output | 1 | New secondary word pulse |
| err_overlap | output | 1 | Tick arrived during gap or secondary frame |

## Verification
The hardest case to reach is a transmit tick that falls inside the four-strobe gap or the secondary frame, because a normal base count leaves enough room for both frames. The bench shortens the base count to 120 clocks and sends code 11 in every primary word, so every other tick lands in a secondary frame. It then counts error pulses and DAC updates to show that those frames were dropped. Adjusted periods are checked by timing the spacing between ticks, with the receive and transmit adjustments given opposite signs so that a swapped side shows up.

// File: rtl/codec_frame_pkg.sv
package codec_frame_pkg;

    typedef enum logic [1:0] {
        CMD_BASE      = 2'b00,
        CMD_LONGER    = 2'b01,
        CMD_SHORTER   = 2'b10,
        CMD_SECONDARY = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_ADD  = 2'd1,
        ADJ_SUB  = 2'd2
    } adj_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PRI  = 2'd1,
        SQ_GAP  = 2'd2,
        SQ_SEC  = 2'd3
    } seq_e;

    function automatic adj_e adj_of_cmd(input cmd_e c);
        case (c)
            CMD_LONGER:  return ADJ_ADD;
            CMD_SHORTER: return ADJ_SUB;
            default:     return ADJ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/codec_period_div.sv
module codec_period_div
    import codec_frame_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        base,
    input  logic signed [CNT_W-1:0] adj,
    input  logic                    cmd_valid,
    input  cmd_e                    cmd,
    output logic                    tick
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic signed [SUM_W-1:0] ONE_S = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] MAX_S = {2'b00, {CNT_W{1'b1}}};

    logic [CNT_W-1:0]        cnt;
    adj_e                    pend;
    logic signed [SUM_W-1:0] base_s, adj_s, sum_s;
    logic [CNT_W-1:0]        load;

    always_comb begin
        base_s = $signed({2'b00, base});
        adj_s  = $signed({{2{adj[CNT_W-1]}}, adj});
        case (pend)
            ADJ_ADD: sum_s = base_s + adj_s;
            ADJ_SUB: sum_s = base_s - adj_s;
            default: sum_s = base_s;
        endcase
        if (sum_s < ONE_S)      load = CNT_W'(1);
        else if (sum_s > MAX_S) load = {CNT_W{1'b1}};
        else                    load = sum_s[CNT_W-1:0];
    end

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CNT_W'(1);
            pend <= ADJ_NONE;
        end else if (tick) begin
            cnt  <= load - CNT_W'(1);
            pend <= cmd_valid ? adj_of_cmd(cmd) : ADJ_NONE;
        end else begin
            cnt <= cnt - CNT_W'(1);
            if (cmd_valid) pend <= adj_of_cmd(cmd);
        end
    end
endmodule

// File: rtl/codec_frame_seq.sv
module codec_frame_seq
    import codec_frame_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int GAP_SHIFTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              start_tick,
    output logic              in_pri,
    output logic              in_sec,
    output logic              pri_last,
    output logic              sec_last,
    output logic [WORD_W-1:0] cap_word,
    output logic              overlap
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int GAP_W = $clog2(GAP_SHIFTS + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_SHIFTS - 1);

    seq_e              state;
    logic [BIT_W-1:0]  bit_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WORD_W-2:0] shreg;
    logic              req;

    assign in_pri   = (state == SQ_PRI);
    assign in_sec   = (state == SQ_SEC);
    assign cap_word = {shreg, sdi};
    assign pri_last = in_pri && shift_en && (bit_cnt == LAST_BIT);
    assign sec_last = in_sec && shift_en && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            bit_cnt <= '0;
            gap_cnt <= '0;
            shreg   <= '0;
            req     <= 1'b0;
            overlap <= 1'b0;
        end else begin
            overlap <= 1'b0;
            if (start_tick) begin
                if (state == SQ_IDLE) req <= 1'b1;
                else if (state == SQ_GAP || state == SQ_SEC) overlap <= 1'b1;
            end
            case (state)
                SQ_IDLE: if ((req || start_tick) && shift_en) begin
                    state   <= SQ_PRI;
                    bit_cnt <= '0;
                    req     <= 1'b0;
                end
                SQ_PRI, SQ_SEC: if (shift_en) begin
                    shreg <= cap_word[WORD_W-2:0];
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        gap_cnt <= '0;
                        if (in_pri && cmd_e'(cap_word[1:0]) == CMD_SECONDARY)
                            state <= SQ_GAP;
                        else
                            state <= SQ_IDLE;
                    end else begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                    end
                end
                SQ_GAP: if (shift_en) begin
                    if (gap_cnt == LAST_GAP) state <= SQ_SEC;
                    else gap_cnt <= gap_cnt + GAP_W'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/codec_cmd_framer.sv
module codec_cmd_framer
    import codec_frame_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WORD_W     = 16,
    parameter int GAP_SHIFTS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic                    sdi,
    input  logic                    dual_mode,
    input  logic                    rx_sdi,
    input  logic [CNT_W-1:0]        base_tx,
    input  logic signed [CNT_W-1:0] adj_tx,
    input  logic [CNT_W-1:0]        base_rx,
    input  logic signed [CNT_W-1:0] adj_rx,
    output logic                    tx_fs_n,
    output logic                    rx_fs_n,
    output logic                    fsd_n,
    output logic                    sdo,
    output logic                    tx_tick,
    output logic                    rx_tick,
    output logic [WORD_W-3:0]       dac_word,
    output logic                    dac_valid,
    output logic [WORD_W-1:0]       sec_word,
    output logic                    sec_valid,
    output logic                    err_overlap
);
    localparam int N_SIDES = 2;
    localparam int DAC_W   = WORD_W - 2;

    logic              in_pri, in_sec, pri_last, sec_last;
    logic [WORD_W-1:0] cap_word;
    logic [CNT_W-1:0]        base_arr [N_SIDES];
    logic signed [CNT_W-1:0] adj_arr  [N_SIDES];
    logic [N_SIDES-1:0]      tick_arr;

    assign base_arr[0] = base_tx;
    assign base_arr[1] = base_rx;
    assign adj_arr[0]  = adj_tx;
    assign adj_arr[1]  = adj_rx;
    assign tx_tick     = tick_arr[0];
    assign rx_tick     = tick_arr[1];

    generate
        for (genvar g = 0; g < N_SIDES; g++) begin : g_div
            codec_period_div #(.CNT_W(CNT_W)) u_div (
                .clk       (clk),
                .rst       (rst),
                .base      (base_arr[g]),
                .adj       (adj_arr[g]),
                .cmd_valid (pri_last),
                .cmd       (cmd_e'(cap_word[1:0])),
                .tick      (tick_arr[g])
            );
        end
    endgenerate

    codec_frame_seq #(.WORD_W(WORD_W), .GAP_SHIFTS(GAP_SHIFTS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .sdi        (sdi),
        .start_tick (tick_arr[0]),
        .in_pri     (in_pri),
        .in_sec     (in_sec),
        .pri_last   (pri_last),
        .sec_last   (sec_last),
        .cap_word   (cap_word),
        .overlap    (err_overlap)
    );

    assign tx_fs_n = !(in_pri || in_sec);
    assign rx_fs_n = !in_pri;
    assign fsd_n   = !(dual_mode && in_sec);
    assign sdo     = (dual_mode && in_sec) ? rx_sdi : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_word  <= '0;
            dac_valid <= 1'b0;
            sec_word  <= '0;
            sec_valid <= 1'b0;
        end else begin
            dac_valid <= pri_last;
            sec_valid <= sec_last;
            if (pri_last) dac_word <= cap_word[WORD_W-1:WORD_W-DAC_W];
            if (sec_last) sec_word <= cap_word;
        end
    end
endmodule

// File: rtl/codec_cmd_framer_chk.sv
module codec_cmd_framer_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dual_mode,
    input logic              rx_sdi,
    input logic              tx_fs_n,
    input logic              rx_fs_n,
    input logic              fsd_n,
    input logic              sdo,
    input logic [WORD_W-3:0] dac_word,
    input logic              dac_valid,
    input logic              sec_valid,
    input logic              err_overlap
);
    assert_rxfs_inside_txfs_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_fs_n |-> !tx_fs_n);

    assert_fsd_secondary_only_R8: assert property (@(posedge clk) disable iff (rst)
        !fsd_n |-> (rx_fs_n && !tx_fs_n && dual_mode));

    assert_sdo_routing_R8: assert property (@(posedge clk) disable iff (rst)
        fsd_n |-> !sdo);

    assert_sdo_follows_R8: assert property (@(posedge clk) disable iff (rst)
        !fsd_n |-> (sdo == rx_sdi));

    assert_dac_from_primary_R1: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> $past(!rx_fs_n));

    assert_dac_held_R1: assert property (@(posedge clk) disable iff (rst)
        !dac_valid |-> $stable(dac_word));

    assert_sec_from_secondary_R6: assert property (@(posedge clk) disable iff (rst)
        sec_valid |-> ($past(rx_fs_n) && $past(!tx_fs_n)));

    assert_one_capture_R6: assert property (@(posedge clk) disable iff (rst)
        !(dac_valid && sec_valid));

    assert_err_outside_primary_R9: assert property (@(posedge clk) disable iff (rst)
        err_overlap |-> rx_fs_n);
endmodule

bind codec_cmd_framer codec_cmd_framer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dual_mode   (dual_mode),
    .rx_sdi      (rx_sdi),
    .tx_fs_n     (tx_fs_n),
    .rx_fs_n     (rx_fs_n),
    .fsd_n       (fsd_n),
    .sdo         (sdo),
    .dac_word    (dac_word),
    .dac_valid   (dac_valid),
    .sec_valid   (sec_valid),
    .err_overlap (err_overlap)
);

// File: tb/tb_codec_cmd_framer.sv
`timescale 1ns/1ps
module tb_codec_cmd_framer;
    localparam int CNT_W = 12;
    localparam int NV    = 7;
    localparam logic [15:0] SEC_SRC = 16'hA5C3;
    // {word[15:0], expected next tx period[11:0], expected next rx period[11:0]}
    // base 200/200, adj_tx = +30, adj_rx = -20
    localparam logic [39:0] VEC [0:NV-1] = '{
        {16'h1230, 12'd200, 12'd200},   // code 00 (R2)
        {16'hBEE1, 12'd230, 12'd180},   // code 01 (R3)
        {16'h7FFC, 12'd200, 12'd200},   // back to base (R5)
        {16'h8002, 12'd170, 12'd220},   // code 10 (R4)
        {16'h5A5B, 12'd200, 12'd200},   // code 11 (R6)
        {16'hC3C1, 12'd230, 12'd180},   // code 01 (R3)
        {16'h0002, 12'd170, 12'd220}    // code 10 (R4)
    };

    logic clk = 0, rst = 1, shift_en = 0, sdi = 0, dual_mode = 0, rx_sdi = 0;
    logic [CNT_W-1:0] base_tx = 200, base_rx = 200;
    logic signed [CNT_W-1:0] adj_tx = 30, adj_rx = -20;
    logic tx_fs_n, rx_fs_n, fsd_n, sdo, tx_tick, rx_tick, dac_valid, sec_valid, err_overlap;
    logic [13:0] dac_word;
    logic [15:0] sec_word;

    always #2.5 clk = ~clk;

    codec_cmd_framer dut (.*);

    int tests = 0, fails = 0, done = 0;
    int cyc = 0, scnt = 0, bidx = 0, pidx = 0, ntx = 0, nrx = 0, ndac = 0, nsec = 0, nerr = 0;
    int ttx [16], trx [16], rxlow_at [16], txlow_at [16];
    logic [13:0] dac_log [16];
    logic [15:0] sec_last, cur, fill_word = 16'h0000;
    int rx_low = 0, tx_low = 0, fsd_low = 0, fsd_pri = 0, sdo_bad = 0, fsd_at_sec = 0;
    int gap_arm = 0, gap_cnt = 0, gap_rec = -1, first_tick = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (tx_tick) begin
            if (ntx < 16) begin ttx[ntx] = cyc; rxlow_at[ntx] = rx_low; txlow_at[ntx] = tx_low; end
            ntx++;
            if (first_tick < 0) first_tick = cyc;
        end
        if (rx_tick) begin if (nrx < 16) trx[nrx] = cyc; nrx++; end
        if (dac_valid) begin if (ndac < 16) dac_log[ndac] = dac_word; ndac++; end
        if (sec_valid) begin sec_last = sec_word; nsec++; fsd_at_sec = fsd_low; end
        if (err_overlap) nerr++;
        if (!rx_fs_n) rx_low++;
        if (!tx_fs_n) tx_low++;
        if (!fsd_n) begin fsd_low++; if (!rx_fs_n) fsd_pri++; end
        if (fsd_n ? (sdo !== 1'b0) : (sdo !== rx_sdi)) sdo_bad++;
        scnt++;
        shift_en = (scnt % 4 == 0);
        if (tx_fs_n) begin
            bidx = 0;
            if (shift_en && gap_arm != 0) gap_cnt++;
        end else if (shift_en) begin
            if (bidx == 0) begin
                if (!rx_fs_n) begin
                    cur = (pidx < NV) ? VEC[pidx][39:24] : fill_word;
                    pidx++;
                    if (cur[1:0] == 2'b11) begin gap_arm = 1; gap_cnt = 0; end
                end else begin
                    cur = SEC_SRC;
                    gap_rec = gap_cnt;
                    gap_arm = 0;
                end
            end
            sdi = cur[15-bidx];
            bidx++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_phase(input logic dual, input logic [CNT_W-1:0] base, input logic [15:0] fill, input int first_idx);
        rst = 1;
        dual_mode = dual; rx_sdi = dual; base_tx = base; base_rx = base; fill_word = fill;
        step(4);
        pidx = first_idx; ntx = 0; nrx = 0; ndac = 0; nsec = 0; nerr = 0;
        rx_low = 0; tx_low = 0; fsd_low = 0; fsd_pri = 0; sdo_bad = 0;
        gap_arm = 0; gap_rec = -1; first_tick = -1;
        rst = 0; cyc = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (done == 0) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(3);
        chk(tx_fs_n && rx_fs_n && fsd_n, "R10 strobes idle in reset", {tx_fs_n, rx_fs_n, fsd_n}, 7);
        chk(!dac_valid && !sec_valid && !err_overlap && !tx_tick, "R10 pulses low in reset",
            {dac_valid, sec_valid, err_overlap, tx_tick}, 0);

        // Phase A: vector table, non-dual
        start_phase(1'b0, 12'd200, 16'h0000, 0);
        chk(tx_fs_n && !dac_valid, "R10 idle after release", tx_fs_n, 1);
        for (int g = 0; g < 4000 && ntx < NV + 2; g++) step(1);
        chk(first_tick == 2, "R10 first tick timing", first_tick, 2);
        chk(ttx[1] - ttx[0] == 200, "R2 base tx period", ttx[1] - ttx[0], 200);
        chk(trx[1] - trx[0] == 200, "R2 base rx period", trx[1] - trx[0], 200);
        for (int k = 0; k < NV; k++) begin
            chk(ttx[k+2] - ttx[k+1] == int'(VEC[k][23:12]), $sformatf("R3/R4/R5 tx period row %0d", k),
                ttx[k+2] - ttx[k+1], int'(VEC[k][23:12]));
            chk(trx[k+2] - trx[k+1] == int'(VEC[k][11:0]), $sformatf("R3/R4/R5 rx period row %0d", k),
                trx[k+2] - trx[k+1], int'(VEC[k][11:0]));
            chk(dac_log[k] == VEC[k][39:26], $sformatf("R1 dac word row %0d", k),
                int'(dac_log[k]), int'(VEC[k][39:26]));
        end
        chk(nsec == 1 && sec_last == SEC_SRC, "R6 secondary captured", int'(sec_last), int'(SEC_SRC));
        chk(gap_rec == 4, "R6 gap length in shifts", gap_rec, 4);
        chk(rxlow_at[NV+1] == 64 * (NV + 1), "R7 rx frame only on primaries", rxlow_at[NV+1], 64 * (NV + 1));
        chk(txlow_at[NV+1] == 64 * (NV + 2), "R7 tx frame covers secondary", txlow_at[NV+1], 64 * (NV + 2));
        chk(fsd_low == 0 && sdo_bad == 0, "R8 no data strobe when not dual", fsd_low, 0);

        // Phase B: dual mode, every primary requests a secondary
        start_phase(1'b1, 12'd200, 16'h9E37, NV);
        for (int g = 0; g < 2000 && nsec < 1; g++) step(1);
        step(2);
        chk(fsd_at_sec == 64, "R8 data strobe spans secondary", fsd_at_sec, 64);
        chk(fsd_pri == 0, "R8 data strobe not in primary", fsd_pri, 0);
        chk(sdo_bad == 0, "R8 sdo routing", sdo_bad, 0);
        chk(ndac == 1 && dac_log[0] == 14'(16'h9E37 >> 2), "R1 dac with code 11", int'(dac_log[0]), int'(16'h9E37 >> 2));
        chk(sec_last == SEC_SRC, "R6 secondary word dual", int'(sec_last), int'(SEC_SRC));

        // Phase C: period too short for primary + secondary
        start_phase(1'b0, 12'd120, 16'h0003, NV);
        step(600);
        chk(nerr == 2, "R9 overlap errors", nerr, 2);
        chk(ndac == 3, "R9 primary frames dropped", ndac, 3);
        chk(nsec == 2 && sec_last == SEC_SRC, "R9 secondary completes", nsec, 2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule